// File: doc/BRIEF.md
# Hamming Row-Column Parity Accumulator

This block builds the check bits of a single-error-correcting Hamming code for a page of NAND data while that data crosses a shared memory bus. It watches every transfer on the bus together with the chip-select index that tags it. It folds into its parity registers only the transfers that target one configured chip-select. It keeps taking data until a programmed number of bytes has been seen, in either 8-bit or 16-bit transfer mode. Software then reads the result and compares it with the code stored in the spare area. Locating and repairing a bad bit is left to software.

There is a single accumulation context. Traffic to any other chip-select may be interleaved freely and leaves the result untouched. On the selected chip-select, reads, writes, commands and status bytes are all treated the same way. Software therefore enables the engine only around the data phase of a page. A clear command starts a new page, and the done flag tells software that the programmed size has been reached and the result is frozen.

Top module: `hamming_par_acc`

## Requirements
- R1: After a synchronous reset, both parity outputs are all zero and `done` is low.
- R2: Column parity, bits [2:0] of each output. For an accepted byte with bit index b (0..7), bit j of `par_even` is toggled by every set data bit whose index has bit j equal to 1. Bit j of `par_odd` is toggled by every set data bit whose index has bit j equal to 0.
- R3: Row parity, bits [ROW_BITS+2:3] of each output. For the byte at page offset a, bit 3+k of `par_even` is toggled by the parity of that byte when bit k of a is 1. Bit 3+k of `par_odd` is toggled by that parity when bit k of a is 0. Offsets count from 0 in the order the bytes were accepted.
- R4: For every bit position, `par_even` XOR `par_odd` equals the parity of all bits accepted so far.
- R5: A transfer whose `bus_cs` differs from `cfg_cs` changes neither output and does not move the page offset.
- R6: While `cfg_en` is low, no transfer changes the outputs or the page offset.
- R7: With `cfg_wide` high, `bus_data[7:0]` is the byte at offset n and `bus_data[15:8]` is the byte at offset n+1, and the offset advances by two per transfer. With `cfg_wide` low, only `bus_data[7:0]` is used and the offset advances by one.
- R8: `done` goes high in the cycle after the transfer that brings the offset to at least `cfg_count` (valid range 1..MAX_BYTES, even in wide mode). From then on, both outputs and `done` hold until a clear.
- R9: `cfg_clear` zeroes both outputs, the page offset and `done` on the next edge. A matching transfer in the same cycle is discarded.
- R10: If two pages differ in a single bit, at offset a and bit index b, then the XOR of their two `par_even` values equals {a, b}.
- R11: The outputs reflect an accepted transfer at the first clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Accumulation enable |
| cfg_cs | input | CS_W | Chip-select the context is bound to |
| cfg_wide | input | 1 | 1 = 16-bit transfers, 0 = 8-bit transfers |
| cfg_count | input | ROW_BITS+1 | Page size in bytes |
| cfg_clear | input | 1 | Restart accumulation (one-cycle pulse) |
| bus_valid | input | 1 | A data transfer is on the bus this cycle |
| bus_cs | input | CS_W | Chip-select of the current transfer |
| bus_data | input | DATA_W | Transfer data |
| par_even | output | ROW_BITS+3 | Even-side parity bits {rows, columns} |
| par_odd | output | ROW_BITS+3 | Complementary parity bits {rows, columns} |
| done | output | 1 | Programmed byte count reached; result frozen |

## Verification
Two functions can meet in the same cycle. A clear can coincide with a matching transfer, and the last transfer of a page can coincide with reaching the programmed count. The bench drives a clear together with a valid transfer on the selected chip-select. It then judges that the outputs are zero and that the next byte lands at offset 0, using a byte whose row and column bits are worked out by hand. The bench also sends further selected traffic after the final transfer, and it checks that `done` rose exactly one edge later and that nothing moved afterwards.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
  localparam int BYTE_W   = 8;
  localparam int COL_BITS = $clog2(BYTE_W);
endpackage

// File: rtl/hpa_lane.sv
module hpa_lane #(
  parameter int ROW_BITS = 9,
  localparam int PAR_W = ROW_BITS + hpa_pkg::COL_BITS
) (
  input  logic [hpa_pkg::BYTE_W-1:0] byte_i,
  input  logic [ROW_BITS-1:0]        addr_i,
  input  logic                       live_i,
  output logic [PAR_W-1:0]           ev_o,
  output logic [PAR_W-1:0]           od_o
);
  import hpa_pkg::*;

  logic bpar;

  always_comb begin
    bpar = ^byte_i;
    ev_o = '0;
    od_o = '0;
    // column terms: split bit positions by each bit of their index
    for (int j = 0; j < COL_BITS; j++) begin
      for (int b = 0; b < BYTE_W; b++) begin
        if (((b >> j) & 1) == 1) ev_o[j] = ev_o[j] ^ byte_i[b];
        else                     od_o[j] = od_o[j] ^ byte_i[b];
      end
    end
    // row terms: split byte parity by each bit of the page offset
    for (int k = 0; k < ROW_BITS; k++) begin
      ev_o[COL_BITS+k] = bpar &  addr_i[k];
      od_o[COL_BITS+k] = bpar & ~addr_i[k];
    end
    if (!live_i) begin
      ev_o = '0;
      od_o = '0;
    end
  end
endmodule

// File: rtl/hpa_ctrl.sv
module hpa_ctrl #(
  parameter int CS_W  = 3,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [CS_W-1:0]  bus_cs_i,
  input  logic [CS_W-1:0]  sel_cs_i,
  input  logic             wide_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             accept_o,
  output logic [CNT_W-1:0] cnt_q,
  output logic             done_q
);
  logic             hit;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    hit      = en_i && valid_i && (bus_cs_i == sel_cs_i);
    accept_o = hit && !done_q && !clear_i;
    step     = wide_i ? CNT_W'(2) : CNT_W'(1);
    nxt      = cnt_q + step;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (accept_o) begin
      cnt_q  <= nxt;
      done_q <= (nxt >= count_i);
    end
  end

  // R8
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(accept_o));

  // R7
  offset_moves_chk: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> (cnt_q != $past(cnt_q)));
endmodule

// File: rtl/hpa_accum.sv
module hpa_accum #(
  parameter int PAR_W = 12,
  parameter int LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clear_i,
  input  logic                        accept_i,
  input  logic [LANES-1:0][PAR_W-1:0] ev_i,
  input  logic [LANES-1:0][PAR_W-1:0] od_i,
  output logic [PAR_W-1:0]            ev_q,
  output logic [PAR_W-1:0]            od_q
);
  logic [PAR_W-1:0] ev_sum, od_sum;

  always_comb begin
    ev_sum = '0;
    od_sum = '0;
    for (int l = 0; l < LANES; l++) begin
      ev_sum = ev_sum ^ ev_i[l];
      od_sum = od_sum ^ od_i[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      ev_q <= '0;
      od_q <= '0;
    end else if (accept_i) begin
      ev_q <= ev_q ^ ev_sum;
      od_q <= od_q ^ od_sum;
    end
  end

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (ev_q == '0) && (od_q == '0));

  for (genvar j = 1; j < PAR_W; j++) begin : g_pair
    // R4
    pair_match_chk: assert property (@(posedge clk) disable iff (rst)
      (ev_q[j] ^ od_q[j]) == (ev_q[0] ^ od_q[0]));
  end
endmodule

// File: rtl/hamming_par_acc.sv
module hamming_par_acc #(
  parameter int DATA_W    = 16,
  parameter int MAX_BYTES = 512,
  parameter int CS_W      = 3,
  localparam int ROW_BITS = $clog2(MAX_BYTES),
  localparam int PAR_W    = ROW_BITS + hpa_pkg::COL_BITS,
  localparam int CNT_W    = ROW_BITS + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic [CS_W-1:0]   cfg_cs,
  input  logic              cfg_wide,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_clear,
  input  logic              bus_valid,
  input  logic [CS_W-1:0]   bus_cs,
  input  logic [DATA_W-1:0] bus_data,
  output logic [PAR_W-1:0]  par_even,
  output logic [PAR_W-1:0]  par_odd,
  output logic              done
);
  import hpa_pkg::*;

  localparam int LANES = DATA_W / BYTE_W;

  logic                        accept;
  logic                        wide_eff;
  logic [CNT_W-1:0]            cnt_q;
  logic [LANES-1:0][PAR_W-1:0] lane_ev, lane_od;

  assign wide_eff = cfg_wide && (LANES > 1);

  hpa_ctrl #(.CS_W(CS_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .clear_i(cfg_clear), .en_i(cfg_en),
    .valid_i(bus_valid), .bus_cs_i(bus_cs), .sel_cs_i(cfg_cs),
    .wide_i(wide_eff), .count_i(cfg_count), .accept_o(accept),
    .cnt_q(cnt_q), .done_q(done)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ROW_BITS-1:0] addr;
    assign addr = cnt_q[ROW_BITS-1:0] + ROW_BITS'(l);
    hpa_lane #(.ROW_BITS(ROW_BITS)) u_lane (
      .byte_i(bus_data[l*BYTE_W +: BYTE_W]),
      .addr_i(addr),
      .live_i((l == 0) || wide_eff),
      .ev_o(lane_ev[l]),
      .od_o(lane_od[l])
    );
  end

  hpa_accum #(.PAR_W(PAR_W), .LANES(LANES)) u_accum (
    .clk(clk), .rst(rst), .clear_i(cfg_clear), .accept_i(accept),
    .ev_i(lane_ev), .od_i(lane_od), .ev_q(par_even), .od_q(par_odd)
  );

  // R5
  foreign_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cs != cfg_cs) && !cfg_clear |=> $stable(par_even) && $stable(par_odd) && $stable(cnt_q));

  // R6
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_en && !cfg_clear |=> $stable(par_even) && $stable(par_odd) && $stable(cnt_q));

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    done && !cfg_clear |=> done && $stable(par_even) && $stable(par_odd));

  // R9
  clear_restart_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_clear |=> (cnt_q == '0) && !done);
endmodule

// File: tb/hamming_par_acc_tb.sv
module hamming_par_acc_tb;
  localparam int PW = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en = 1'b0;
  logic [2:0]  cfg_cs = 3'd0;
  logic        cfg_wide = 1'b0;
  logic [9:0]  cfg_count = 10'd16;
  logic        cfg_clear = 1'b0;
  logic        bus_valid = 1'b0;
  logic [2:0]  bus_cs = 3'd0;
  logic [15:0] bus_data = 16'd0;
  logic [PW-1:0] par_even, par_odd;
  logic        done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] m_buf [512];
  logic [7:0] page  [64];
  int m_n = 0;

  always #2.5 clk = ~clk;

  hamming_par_acc u_dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_cs(cfg_cs), .cfg_wide(cfg_wide),
    .cfg_count(cfg_count), .cfg_clear(cfg_clear), .bus_valid(bus_valid),
    .bus_cs(bus_cs), .bus_data(bus_data), .par_even(par_even), .par_odd(par_odd),
    .done(done)
  );

  // reference: walk every set bit of every accepted byte
  function automatic void calc(output logic [PW-1:0] e, output logic [PW-1:0] o);
    e = '0; o = '0;
    for (int i = 0; i < m_n; i++)
      for (int b = 0; b < 8; b++)
        if (m_buf[i][b]) begin
          for (int j = 0; j < 3; j++)
            if (((b >> j) & 1) == 1) e[j] = ~e[j]; else o[j] = ~o[j];
          for (int k = 0; k < 9; k++)
            if (((i >> k) & 1) == 1) e[3+k] = ~e[3+k]; else o[3+k] = ~o[3+k];
        end
  endfunction

  task automatic chk(string req, string what, logic [PW-1:0] act, logic [PW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_state(string req);
    logic [PW-1:0] e, o;
    calc(e, o);
    chk(req, "par_even", par_even, e);
    chk(req, "par_odd", par_odd, o);
    chk(req, "done", PW'(done), PW'(m_n >= int'(cfg_count)));
  endtask

  // one bus cycle, entered and left at a falling edge
  task automatic drive(bit v, logic [2:0] cs, logic [15:0] d, bit clr);
    bus_valid = v; bus_cs = cs; bus_data = d; cfg_clear = clr;
    if (clr) m_n = 0;
    else if (v && cfg_en && cs == cfg_cs && m_n < int'(cfg_count)) begin
      m_buf[m_n] = d[7:0];
      m_n++;
      if (cfg_wide) begin
        m_buf[m_n] = d[15:8];
        m_n++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; cfg_clear = 1'b0;
  endtask

  task automatic setup(bit wide, int cnt, logic [2:0] cs);
    cfg_en = 1'b1; cfg_wide = wide; cfg_count = 10'(cnt); cfg_cs = cs;
    drive(1'b0, cs, 16'd0, 1'b1);
  endtask

  task automatic rand_page(bit wide, int cnt, logic [2:0] cs);
    setup(wide, cnt, cs);
    while (m_n < cnt) begin
      int r = int'($urandom % 8);
      if (r == 0)      drive(1'b0, cs, 16'($urandom), 1'b0);
      else if (r == 1) drive(1'b1, cs ^ 3'(1 + $urandom % 7), 16'($urandom), 1'b0);
      else             drive(1'b1, cs, 16'($urandom), 1'b0);
      check_state("R11");
    end
    check_state("R8");
    for (int i = 0; i < 3; i++) drive(1'b1, cs, 16'($urandom), 1'b0);
    check_state("R8");
  endtask

  task automatic send_page(int flip_a, int flip_b);
    setup(1'b0, 64, 3'd5);
    for (int i = 0; i < 64; i++) begin
      logic [7:0] v = page[i];
      if (i == flip_a) v[flip_b] = ~v[flip_b];
      drive(1'b1, 3'd5, {8'h00, v}, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] e_ref, e_flip;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "par_even", par_even, '0);
    chk("R1", "par_odd", par_odd, '0);
    chk("R1", "done", PW'(done), '0);

    // R2 single byte at offset 0
    setup(1'b0, 4, 3'd2);
    drive(1'b1, 3'd2, 16'h0001, 1'b0);
    chk("R2", "par_even", par_even, 12'h000);
    chk("R2", "par_odd", par_odd, 12'hFFF);
    // R3 byte 0x80 at offset 1
    drive(1'b1, 3'd2, 16'h0080, 1'b0);
    chk("R3", "par_even", par_even, 12'h00F);
    chk("R3", "par_odd", par_odd, 12'h00F);
    // R6 disabled engine
    cfg_en = 1'b0;
    drive(1'b1, 3'd2, 16'h00FE, 1'b0);
    cfg_en = 1'b1;
    chk("R6", "par_even", par_even, 12'h00F);
    // R5 foreign chip-select
    drive(1'b1, 3'd3, 16'h0013, 1'b0);
    drive(1'b1, 3'd0, 16'h0013, 1'b0);
    chk("R5", "par_odd", par_odd, 12'h00F);
    check_state("R4");

    // R9 clear together with a matching transfer
    drive(1'b1, 3'd2, 16'h00FF, 1'b1);
    chk("R9", "par_even", par_even, 12'h000);
    chk("R9", "par_odd", par_odd, 12'h000);
    drive(1'b1, 3'd2, 16'h0002, 1'b0);
    chk("R9", "first byte even", par_even, 12'h001);
    chk("R9", "first byte odd", par_odd, 12'hFFE);

    // R7 wide mode, little-endian byte order
    setup(1'b1, 4, 3'd1);
    drive(1'b1, 3'd1, 16'h8001, 1'b0);
    chk("R7", "par_even", par_even, 12'h00F);
    chk("R7", "par_odd", par_odd, 12'h00F);
    chk("R7", "done", PW'(done), '0);
    drive(1'b1, 3'd1, 16'h0000, 1'b0);
    chk("R8", "done at count", PW'(done), 12'h001);
    drive(1'b1, 3'd1, 16'hFFFF, 1'b0);
    chk("R8", "frozen even", par_even, 12'h00F);

    // R10 single-bit syndrome
    for (int i = 0; i < 64; i++) page[i] = 8'($urandom);
    send_page(-1, 0);
    e_ref = par_even;
    check_state("R2");
    send_page(37, 6);
    e_flip = par_even;
    chk("R10", "syndrome", e_ref ^ e_flip, {9'd37, 3'd6});

    // mixed random pages
    rand_page(1'b1, 512, 3'd7);
    rand_page(1'b0, 40, 3'd0);
    for (int p = 0; p < 5; p++)
      rand_page(1'($urandom % 2), 2 * (1 + int'($urandom % 100)), 3'($urandom));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule